// File: doc/BRIEF.md
# Chainable PWM Time-Base Counter

This block is the timing heart of one PWM channel. A counter advances on a prescaled tick and runs in one of three shapes: a rising sawtooth, a falling sawtooth, or a triangle that turns around at a programmable period value and at zero. When counting steps onto zero or onto the period, a single-cycle flag is raised. Downstream compare logic uses these flags. Several identical instances can be chained: the sync output of one feeds the sync input of the next. A sync event can load a per-channel phase offset and a starting direction, so the channels keep fixed phase relations to each other.

A global clock enable holds every counter in the chain frozen. All of them start on the same edge once it rises. A software-forced sync acts exactly like the external sync input. A sticky flag records that a sync event was seen until it is cleared.

The counter is a three-state machine: `ST_STOP` (not counting), `ST_UP` and `ST_DOWN`. The transitions are:
- `ST_STOP`→`ST_UP` or `ST_DOWN`, when the mode selects up or up-down, or down.
- `ST_UP`→`ST_DOWN`, at the period in triangle mode, or when the mode is changed to down.
- `ST_DOWN`→`ST_UP`, at zero in triangle mode, or when the mode is changed to up.
- Any state → `ST_STOP`, when the mode is stop.
- Any state → the state given by the mode and the direction bit, on a phase load.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the counter is 0, and `at_zero`, `at_period`, `sync_out` and `sync_seen` are all 0.
- R2: While `tb_en` is 0 the counter holds its value, except for phase loads. Counting resumes on the first edge with `tb_en` at 1.
- R3: A counter step occurs once every H×C enabled cycles. H is 1 for `hs_div`=0 and 2·`hs_div` otherwise, and C is 2^`ck_div`.
- R4: In mode 0 (up) each step adds 1, and a step taken at or above `period` goes to 0.
- R5: In mode 1 (down) each step subtracts 1, and a step taken at 0 goes to `period`.
- R6: In mode 2 (triangle) the counter rises to `period`, then falls to 0, then rises again. Each turnaround value is visited once per sweep.
- R7: `at_zero` (or `at_period`) is high for exactly one cycle, namely the cycle after a step lands the counter on 0 (or on `period`). It stays low for the remaining cycles the counter rests there.
- R8: With `phase_en`=1, a sync event loads `phase` into the counter on that edge, taking priority over a step. In mode 2 the next step then goes up if `phase_dir`=1 and down if `phase_dir`=0.
- R9: With `phase_en`=0, a sync event leaves the counter stepping as normal.
- R10: `sync_sel` chooses the sync output: 0 repeats the sync event one clock later, 1 pulses when a step lands on 0, 2 pulses when a step lands on `cmpb`, and 3 keeps the output low.
- R11: A pulse on `sw_sync` has the same effect as a pulse on `sync_in`.
- R12: `sync_seen` goes to 1 on the edge after any sync event and stays there. A pulse on `seen_clr` clears it, but a sync event in the same cycle keeps it at 1.
- R13: In mode 3 (stop) the counter does not step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tb_en | input | 1 | Global time-base enable shared by the chain |
| mode | input | 2 | 0 up, 1 down, 2 triangle, 3 stop |
| hs_div | input | 3 | First prescaler stage code |
| ck_div | input | 3 | Second prescaler stage code |
| period | input | 16 | Period value |
| phase | input | 16 | Value loaded on sync |
| phase_en | input | 1 | Enables phase load on sync |
| phase_dir | input | 1 | Direction after load in triangle mode, 1 = up |
| cmpb | input | 16 | Match value for sync output select 2 |
| sync_sel | input | 2 | Sync output source select |
| sync_in | input | 1 | Sync from the previous stage |
| sw_sync | input | 1 | Software-forced sync pulse |
| seen_clr | input | 1 | Clears the sticky sync flag |
| cnt | output | 16 | Counter value |
| at_zero | output | 1 | Step landed on zero |
| at_period | output | 1 | Step landed on period |
| sync_out | output | 1 | Sync to the next stage |
| sync_seen | output | 1 | Sticky sync-event flag |

## Verification
The assertions rely on these conditions about the inputs:
- `period` does not change while the counter runs in triangle mode.
- The zero flag is checked against the counter value only when nothing reloads it in between.
- `sync_in` and `sw_sync` are treated as synchronous pulses.

The stimulus respects this: every input is driven on the falling edge, each configuration is set up while `tb_en` is low after a reset, and a phase or period is only changed in a cycle that carries the sync pulse using it.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;
    typedef enum logic [1:0] {
        MODE_UP     = 2'd0,
        MODE_DOWN   = 2'd1,
        MODE_UPDOWN = 2'd2,
        MODE_STOP   = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        SO_PASS = 2'd0,
        SO_ZERO = 2'd1,
        SO_CMPB = 2'd2,
        SO_OFF  = 2'd3
    } sync_sel_e;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } dir_state_e;
endpackage

// File: rtl/pwm_tb_prescale.sv
module pwm_tb_prescale #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] hs_code,
    input  logic [DIV_W-1:0] ck_code,
    output logic             tick
);
    localparam int HS_W = DIV_W + 1;
    localparam int CK_W = (1 << DIV_W) - 1;

    logic [HS_W-1:0] hs_cnt, hs_last;
    logic [CK_W-1:0] ck_cnt, ck_last;
    logic            hs_wrap;

    always_comb begin
        hs_last = (hs_code == '0) ? '0 : HS_W'((32'(hs_code) << 1) - 1);
        ck_last = CK_W'((33'd1 << ck_code) - 33'd1);
        hs_wrap = en && (hs_cnt >= hs_last);
        tick    = hs_wrap && (ck_cnt >= ck_last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_cnt <= '0;
            ck_cnt <= '0;
        end else if (!en) begin
            hs_cnt <= '0;
            ck_cnt <= '0;
        end else begin
            hs_cnt <= hs_wrap ? '0 : hs_cnt + 1'b1;
            if (hs_wrap)
                ck_cnt <= tick ? '0 : ck_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  cnt_mode_e        mode,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] phase,
    input  logic             phase_dir,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             step,
    output logic             at_zero,
    output logic             at_period
);
    dir_state_e state, state_nxt;
    logic       adv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_STOP;
            cnt       <= '0;
            at_zero   <= 1'b0;
            at_period <= 1'b0;
        end else begin
            state     <= state_nxt;
            cnt       <= cnt_nxt;
            at_zero   <= step && (cnt_nxt == '0);
            at_period <= step && (cnt_nxt == period);
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        step      = 1'b0;
        adv       = tick && (mode != MODE_STOP);
        if (load) begin
            cnt_nxt = phase;
            unique case (mode)
                MODE_UP:     state_nxt = ST_UP;
                MODE_DOWN:   state_nxt = ST_DOWN;
                MODE_UPDOWN: state_nxt = phase_dir ? ST_UP : ST_DOWN;
                MODE_STOP:   state_nxt = ST_STOP;
            endcase
        end else begin
            unique case (state)
                ST_STOP: ;
                ST_UP: if (adv) begin
                    step = 1'b1;
                    if (mode == MODE_UPDOWN && cnt >= period) begin
                        cnt_nxt   = (period == '0) ? '0 : cnt - 1'b1;
                        state_nxt = ST_DOWN;
                    end else if (mode != MODE_UPDOWN && cnt >= period) begin
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
                ST_DOWN: if (adv) begin
                    step = 1'b1;
                    if (mode == MODE_UPDOWN && cnt == '0) begin
                        cnt_nxt   = (period == '0) ? '0 : CNT_W'(1);
                        state_nxt = ST_UP;
                    end else if (cnt == '0) begin
                        cnt_nxt = period;
                    end else begin
                        cnt_nxt = cnt - 1'b1;
                    end
                end
                default: state_nxt = ST_STOP;
            endcase
            if (mode == MODE_UP)        state_nxt = ST_UP;
            else if (mode == MODE_DOWN) state_nxt = ST_DOWN;
            else if (mode == MODE_STOP) state_nxt = ST_STOP;
            else if (state == ST_STOP)  state_nxt = ST_UP;
        end
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt));
    assert_phase_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(phase)));
    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        at_zero |-> (cnt == '0));
    assert_tri_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_UPDOWN && !load && cnt <= period) |=> (cnt <= $past(period)));
endmodule

// File: rtl/pwm_tb_sync.sv
module pwm_tb_sync
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  logic             sw_sync,
    input  sync_sel_e        sel,
    input  logic             step,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] cmpb,
    input  logic             seen_clr,
    output logic             sync_evt,
    output logic             sync_out,
    output logic             sync_seen
);
    logic out_nxt;

    always_comb begin
        sync_evt = sync_in || sw_sync;
        unique case (sel)
            SO_PASS: out_nxt = sync_evt;
            SO_ZERO: out_nxt = step && (cnt_nxt == '0);
            SO_CMPB: out_nxt = step && (cnt_nxt == cmpb);
            SO_OFF:  out_nxt = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_out  <= 1'b0;
            sync_seen <= 1'b0;
        end else begin
            sync_out  <= out_nxt;
            sync_seen <= sync_evt || (sync_seen && !seen_clr);
        end
    end

    assert_pass_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SO_PASS && sync_evt) |=> sync_out);
    assert_sticky_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sync_evt |=> sync_seen);
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tb_en,
    input  logic [1:0]       mode,
    input  logic [DIV_W-1:0] hs_div,
    input  logic [DIV_W-1:0] ck_div,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] phase,
    input  logic             phase_en,
    input  logic             phase_dir,
    input  logic [CNT_W-1:0] cmpb,
    input  logic [1:0]       sync_sel,
    input  logic             sync_in,
    input  logic             sw_sync,
    input  logic             seen_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             at_zero,
    output logic             at_period,
    output logic             sync_out,
    output logic             sync_seen
);
    logic             tick, step, sync_evt;
    logic [CNT_W-1:0] cnt_nxt;

    pwm_tb_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(tb_en),
        .hs_code(hs_div), .ck_code(ck_div), .tick(tick)
    );

    pwm_tb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .load(phase_en && sync_evt), .mode(cnt_mode_e'(mode)),
        .period(period), .phase(phase), .phase_dir(phase_dir),
        .cnt(cnt), .cnt_nxt(cnt_nxt), .step(step),
        .at_zero(at_zero), .at_period(at_period)
    );

    pwm_tb_sync #(.CNT_W(CNT_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sw_sync(sw_sync),
        .sel(sync_sel_e'(sync_sel)), .step(step), .cnt_nxt(cnt_nxt),
        .cmpb(cmpb), .seen_clr(seen_clr), .sync_evt(sync_evt),
        .sync_out(sync_out), .sync_seen(sync_seen)
    );
endmodule

// File: tb/test_pwm_timebase.sv
module test_pwm_timebase;
    logic        clk = 1'b0;
    logic        rst_n, tb_en, phase_en, phase_dir, sync_in, sw_sync, seen_clr;
    logic [1:0]  mode, sync_sel;
    logic [2:0]  hs_div, ck_div;
    logic [15:0] period, phase, cmpb, cnt;
    logic        at_zero, at_period, sync_out, sync_seen;
    int          n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    pwm_timebase i_pwm_timebase (
        .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .mode(mode), .hs_div(hs_div),
        .ck_div(ck_div), .period(period), .phase(phase), .phase_en(phase_en),
        .phase_dir(phase_dir), .cmpb(cmpb), .sync_sel(sync_sel), .sync_in(sync_in),
        .sw_sync(sw_sync), .seen_clr(seen_clr), .cnt(cnt), .at_zero(at_zero),
        .at_period(at_period), .sync_out(sync_out), .sync_seen(sync_seen)
    );

    typedef struct packed {
        logic [1:0]  md;
        logic [15:0] per;
        logic [2:0]  hs;
        logic [2:0]  ck;
        logic [15:0] n;
        logic [15:0] exp;
    } vec_t;

    // mode, period, hs, ck, enabled cycles, expected count
    localparam vec_t VECS [13] = '{
        '{2'd0, 16'd4,  3'd0, 3'd0, 16'd3,  16'd3},  // R4
        '{2'd0, 16'd4,  3'd0, 3'd0, 16'd7,  16'd2},  // R4 wrap
        '{2'd1, 16'd4,  3'd0, 3'd0, 16'd1,  16'd4},  // R5
        '{2'd1, 16'd4,  3'd0, 3'd0, 16'd6,  16'd4},  // R5
        '{2'd2, 16'd4,  3'd0, 3'd0, 16'd6,  16'd2},  // R6
        '{2'd2, 16'd4,  3'd0, 3'd0, 16'd9,  16'd1},  // R6
        '{2'd0, 16'd9,  3'd1, 3'd0, 16'd10, 16'd5},  // R3
        '{2'd0, 16'd9,  3'd0, 3'd2, 16'd13, 16'd3},  // R3
        '{2'd0, 16'd15, 3'd2, 3'd1, 16'd40, 16'd5},  // R3
        '{2'd2, 16'd3,  3'd0, 3'd1, 16'd14, 16'd1},  // R3 R6
        '{2'd1, 16'd7,  3'd3, 3'd0, 16'd30, 16'd3},  // R3 R5
        '{2'd0, 16'd0,  3'd0, 3'd0, 16'd5,  16'd0},  // R4 zero period
        '{2'd3, 16'd4,  3'd0, 3'd0, 16'd5,  16'd0}   // R13
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] md, input logic [15:0] per);
        @(negedge clk);
        rst_n = 0; tb_en = 0; phase_en = 0; phase_dir = 0; sync_in = 0;
        sw_sync = 0; seen_clr = 0; mode = md; sync_sel = 2'd3;
        hs_div = 0; ck_div = 0; period = per; phase = 0; cmpb = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_sync(input bit sw);
        if (sw) sw_sync = 1; else sync_in = 1;
        @(negedge clk);
        sw_sync = 0; sync_in = 0;
    endtask

    int zc, pc, mism, c0;

    initial begin
        #4000000;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset(2'd0, 16'd4);
        check(cnt == 0 && !at_zero && !at_period && !sync_out && !sync_seen,
              "R1", int'(cnt), 0);

        foreach (VECS[i]) begin
            do_reset(VECS[i].md, VECS[i].per);
            hs_div = VECS[i].hs; ck_div = VECS[i].ck;
            @(negedge clk);
            tb_en = 1;
            repeat (int'(VECS[i].n)) @(negedge clk);
            tb_en = 0;
            check(cnt == VECS[i].exp, "R3/R4/R5/R6/R13 vector", int'(cnt), int'(VECS[i].exp));
        end

        // R2 hold while disabled, resume on first enabled edge
        do_reset(2'd0, 16'd9);
        tb_en = 1; repeat (3) @(negedge clk);
        tb_en = 0; c0 = int'(cnt);
        repeat (5) @(negedge clk);
        check(int'(cnt) == c0, "R2 hold", int'(cnt), c0);
        tb_en = 1; @(negedge clk);
        check(int'(cnt) == c0 + 1, "R2 resume", int'(cnt), c0 + 1);

        // R7 one-cycle flags with prescaler 2 in up mode
        do_reset(2'd0, 16'd2);
        hs_div = 1; @(negedge clk);
        tb_en = 1; zc = 0; pc = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            zc += int'(at_zero); pc += int'(at_period);
        end
        check(zc == 2, "R7 zero pulses", zc, 2);
        check(pc == 2, "R7 period pulses", pc, 2);

        // R6 R7 triangle turnarounds
        do_reset(2'd2, 16'd3);
        tb_en = 1; zc = 0; pc = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            zc += int'(at_zero); pc += int'(at_period);
        end
        check(zc == 2, "R6 zero turnarounds", zc, 2);
        check(pc == 2, "R6 period turnarounds", pc, 2);

        // R8 phase load beats a step
        do_reset(2'd0, 16'd9);
        tb_en = 1; repeat (2) @(negedge clk);
        phase_en = 1; phase = 6;
        pulse_sync(0);
        check(cnt == 6, "R8 load", int'(cnt), 6);
        @(negedge clk);
        check(cnt == 7, "R8 after load", int'(cnt), 7);

        // R8 direction bit in triangle mode
        do_reset(2'd2, 16'd9);
        tb_en = 1; repeat (2) @(negedge clk);
        phase_en = 1; phase = 5; phase_dir = 0;
        pulse_sync(0);
        @(negedge clk);
        check(cnt == 4, "R8 dir down", int'(cnt), 4);
        phase_dir = 1;
        pulse_sync(0);
        @(negedge clk);
        check(cnt == 6, "R8 dir up", int'(cnt), 6);

        // R9 sync ignored without phase enable
        do_reset(2'd0, 16'd9);
        tb_en = 1; repeat (4) @(negedge clk);
        phase = 1; c0 = int'(cnt);
        pulse_sync(0);
        check(int'(cnt) == (c0 + 1) % 10, "R9", int'(cnt), (c0 + 1) % 10);

        // R11 software sync loads phase
        do_reset(2'd0, 16'd9);
        tb_en = 1; repeat (1) @(negedge clk);
        phase_en = 1; phase = 8;
        pulse_sync(1);
        check(cnt == 8, "R11", int'(cnt), 8);

        // R10 pass-through with one clock delay
        do_reset(2'd0, 16'd9);
        sync_sel = 2'd0;
        pulse_sync(0);
        check(sync_out == 1, "R10 pass", int'(sync_out), 1);
        @(negedge clk);
        check(sync_out == 0, "R10 pass end", int'(sync_out), 0);

        // R10 zero, compare and off sources
        for (int s = 1; s < 4; s++) begin
            do_reset(2'd0, 16'd3);
            sync_sel = 2'(s); cmpb = 2;
            tb_en = 1; mism = 0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (sync_out !== ((s == 1) ? (cnt == 0) : (s == 2) ? (cnt == 2) : 1'b0))
                    mism++;
            end
            check(mism == 0, "R10 select", mism, 0);
        end

        // R12 sticky flag, clear, set-over-clear
        do_reset(2'd0, 16'd9);
        pulse_sync(0);
        repeat (3) @(negedge clk);
        check(sync_seen == 1, "R12 sticky", int'(sync_seen), 1);
        seen_clr = 1; @(negedge clk); seen_clr = 0;
        check(sync_seen == 0, "R12 clear", int'(sync_seen), 0);
        seen_clr = 1; pulse_sync(1); seen_clr = 0;
        check(sync_seen == 1, "R12 set wins", int'(sync_seen), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule